// File: doc/BRIEF.md
# Processor Mode and Stack Selector

This block keeps the execution state of a small microcontroller core: whether it runs in Thread or Handler mode, whether Thread code is privileged or user level, and which of two banked stack pointers (main or process) is active. It also carries out the boot fetch that follows reset. The first two words of the vector table are read through a simple one-word read port. The word at offset 0 becomes the main stack pointer. The word at offset 4 becomes the start address, which goes to the fetch unit as a one-cycle program counter load.

The surrounding core drives three things. It signals exception entry with an exception number and exception return with a strobe. It writes the two-bit control register through a small write port. It writes the current stack pointer through a data port. Mode, privilege, stack select, both banked stack pointers and the active exception number are visible as outputs.

Top module: `mode_stack_ctrl`

## Requirements
- R1: While `rst` is high and in the first cycle after it falls, the block is in Thread mode (`mode_handler`=0) at the privileged level (`priv`=1), with the main stack selected (`sp_sel_psp`=0), `psp`=0, `exc_field`=0 and `boot_done`=0.
- R2: After reset, `mem_req` is high with `mem_addr`=0 until a cycle with `mem_valid`=1. That word, with its two low bits cleared, is loaded into `msp`. From the next cycle `mem_addr`=4 until the next `mem_valid`.
- R3: In the cycle after the edge that captures the word from address 4, `pc_load`=1 for exactly one cycle and `pc_value` equals that word. `boot_done` rises on the following edge and stays high.
- R4: Control write data bit 0 sets the Thread privilege: 0 gives privileged (`priv`=1), 1 gives user (`priv`=0).
- R5: Control write data bit 1 sets the Thread stack: 0 selects the main stack (`sp_sel_psp`=0), 1 selects the process stack (`sp_sel_psp`=1).
- R6: Handler mode is entered only when `exc_enter` is high with a non-zero `exc_num`; an entry with number 0 has no effect. In Handler mode `priv`=1 and `sp_sel_psp`=0 whatever the control bits hold.
- R7: `exc_field` holds the number of the latest accepted entry while in Handler mode and is 0 in Thread mode. A new entry while in Handler mode replaces the number.
- R8: `exc_return` in Handler mode returns to Thread mode. In Thread mode it is ignored. When entry and return arrive in the same cycle, the entry wins.
- R9: A control write is ignored while in user-level Thread mode. It is accepted in Handler mode and in privileged Thread mode, and it governs Thread behaviour after return.
- R10: A change of mode or control bits appears on `priv` and `sp_sel_psp` from the clock edge that registers it onward.
- R11: `sp_wr` writes `sp_wdata`, with its two low bits cleared, into the currently selected bank only; the other bank holds its value.
- R12: Until `boot_done` is high, `exc_enter`, `exc_return`, `ctrl_wr` and `sp_wr` have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| exc_enter | input | 1 | Exception entry strobe |
| exc_num | input | EXC_W | Number of the entered exception |
| exc_return | input | 1 | Exception return strobe |
| ctrl_wr | input | 1 | Control register write strobe |
| ctrl_wdata | input | 2 | Bit 0 user-level Thread, bit 1 process stack in Thread |
| sp_wr | input | 1 | Write strobe for the selected stack pointer |
| sp_wdata | input | DATA_W | Stack pointer write value |
| mem_req | output | 1 | Boot word read request |
| mem_addr | output | ADDR_W | Boot word address |
| mem_valid | input | 1 | Read data valid |
| mem_rdata | input | DATA_W | Read data |
| pc_load | output | 1 | One-cycle start-address load strobe |
| pc_value | output | DATA_W | Start address |
| boot_done | output | 1 | Boot fetch complete |
| mode_handler | output | 1 | 1 in Handler mode, 0 in Thread mode |
| priv | output | 1 | Current privilege, 1 privileged |
| sp_sel_psp | output | 1 | 1 when the process stack is active |
| msp | output | DATA_W | Main stack pointer |
| psp | output | DATA_W | Process stack pointer |
| exc_field | output | EXC_W | Active exception number, 0 in Thread mode |

## Verification
The bench uses the default widths: 32-bit data and address, and an 8-bit exception number. Every number from 0 to 255 can therefore be drawn, so the ignored zero entry and the largest number both come up. Boot runs with memory latencies of zero and two cycles, so both a back-to-back capture and a stalled fetch are exercised. Random strobes make entry, return, privileged and unprivileged control writes and stack writes collide in the same cycle, which exercises the priority rules.

// File: rtl/mode_stack_pkg.sv
package mode_stack_pkg;

    typedef enum logic {
        MODE_THREAD  = 1'b0,
        MODE_HANDLER = 1'b1
    } exec_mode_e;

    typedef enum logic [1:0] {
        BOOT_SP  = 2'd0,
        BOOT_PC  = 2'd1,
        BOOT_GO  = 2'd2,
        BOOT_RUN = 2'd3
    } boot_state_e;

    typedef struct packed {
        logic psp_thread;
        logic user_thread;
    } ctrl_bits_t;

    localparam int unsigned VEC_STRIDE = 4;

endpackage

// File: rtl/boot_seq.sv
module boot_seq
    import mode_stack_pkg::*;
#(
    parameter int unsigned ADDR_W = 32,
    parameter int unsigned DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              mem_valid,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              mem_req,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              sp_boot_wr,
    output logic              pc_load,
    output logic [DATA_W-1:0] pc_value,
    output logic              boot_done
);

    boot_state_e       state_q;
    logic [DATA_W-1:0] start_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= BOOT_SP;
            start_q <= '0;
        end else begin
            unique case (state_q)
                BOOT_SP: if (mem_valid) state_q <= BOOT_PC;
                BOOT_PC: if (mem_valid) begin
                    start_q <= mem_rdata;
                    state_q <= BOOT_GO;
                end
                BOOT_GO:  state_q <= BOOT_RUN;
                default:  state_q <= BOOT_RUN;
            endcase
        end
    end

    always_comb begin
        mem_req    = (state_q == BOOT_SP) || (state_q == BOOT_PC);
        mem_addr   = (state_q == BOOT_PC) ? ADDR_W'(VEC_STRIDE) : '0;
        sp_boot_wr = (state_q == BOOT_SP) && mem_valid;
        pc_load    = (state_q == BOOT_GO);
        pc_value   = start_q;
        boot_done  = (state_q == BOOT_RUN);
    end

    // R3
    go_after_capture_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q == BOOT_PC && mem_valid) |=> pc_load);

    // R3
    single_load_chk: assert property (@(posedge clk) disable iff (rst)
        pc_load |=> (!pc_load && boot_done));

    // R2
    fetch_order_chk: assert property (@(posedge clk) disable iff (rst)
        (mem_req && mem_addr == '0 && mem_valid) |=> (mem_req && mem_addr == ADDR_W'(VEC_STRIDE)));

endmodule

// File: rtl/sp_bank.sv
module sp_bank #(
    parameter int unsigned DATA_W   = 32,
    parameter int unsigned SP_ALIGN = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              boot_wr,
    input  logic [DATA_W-1:0] boot_val,
    input  logic              sp_wr,
    input  logic              sel_psp,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] msp,
    output logic [DATA_W-1:0] psp
);

    localparam logic [DATA_W-1:0] ALIGN_MASK = ~DATA_W'((64'd1 << SP_ALIGN) - 64'd1);

    logic [DATA_W-1:0] bank_q [2];
    logic [1:0]        bank_we;
    logic [DATA_W-1:0] bank_d [2];

    // bank 0 = main stack, bank 1 = process stack
    for (genvar b = 0; b < 2; b++) begin : g_bank
        if (b == 0) begin : g_main
            assign bank_we[b] = boot_wr || (sp_wr && !sel_psp);
            assign bank_d[b]  = (boot_wr ? boot_val : wdata) & ALIGN_MASK;
        end else begin : g_proc
            assign bank_we[b] = !boot_wr && sp_wr && sel_psp;
            assign bank_d[b]  = wdata & ALIGN_MASK;
        end

        always_ff @(posedge clk) begin
            if (rst)              bank_q[b] <= '0;
            else if (bank_we[b])  bank_q[b] <= bank_d[b];
        end
    end

    assign msp = bank_q[0];
    assign psp = bank_q[1];

    // R11
    psp_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!(sp_wr && sel_psp)) |=> $stable(psp));

    // R11
    msp_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!boot_wr && !(sp_wr && !sel_psp)) |=> $stable(msp));

endmodule

// File: rtl/mode_tracker.sv
module mode_tracker
    import mode_stack_pkg::*;
#(
    parameter int unsigned EXC_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic             exc_enter,
    input  logic [EXC_W-1:0] exc_num,
    input  logic             exc_return,
    input  logic             ctrl_wr,
    input  logic [1:0]       ctrl_wdata,
    output logic             mode_handler,
    output logic             priv,
    output logic             sel_psp,
    output logic [EXC_W-1:0] exc_field
);

    exec_mode_e       mode_q;
    ctrl_bits_t       ctrl_q;
    logic [EXC_W-1:0] exc_q;
    logic             enter_ok;
    logic             leave_ok;
    logic             ctrl_ok;

    always_comb begin
        priv     = (mode_q == MODE_HANDLER) || !ctrl_q.user_thread;
        sel_psp  = (mode_q == MODE_THREAD) && ctrl_q.psp_thread;
        enter_ok = run && exc_enter && (exc_num != '0);
        leave_ok = run && exc_return && (mode_q == MODE_HANDLER) && !enter_ok;
        ctrl_ok  = run && ctrl_wr && priv;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q <= MODE_THREAD;
            ctrl_q <= '0;
            exc_q  <= '0;
        end else begin
            if (ctrl_ok) ctrl_q <= ctrl_bits_t'(ctrl_wdata);
            if (enter_ok) begin
                mode_q <= MODE_HANDLER;
                exc_q  <= exc_num;
            end else if (leave_ok) begin
                mode_q <= MODE_THREAD;
                exc_q  <= '0;
            end
        end
    end

    assign mode_handler = (mode_q == MODE_HANDLER);
    assign exc_field    = exc_q;

    // R1
    reset_state_chk: assert property (@(posedge clk)
        rst |=> (mode_q == MODE_THREAD && ctrl_q == '0 && exc_q == '0));

    // R7
    exc_field_chk: assert property (@(posedge clk) disable iff (rst)
        (mode_q == MODE_THREAD) == (exc_q == '0));

    // R9
    user_ctrl_lock_chk: assert property (@(posedge clk) disable iff (rst)
        (mode_q == MODE_THREAD && ctrl_q.user_thread) |=> $stable(ctrl_q));

    // R8
    stray_return_chk: assert property (@(posedge clk) disable iff (rst)
        (mode_q == MODE_THREAD && !(run && exc_enter && exc_num != '0)) |=> (mode_q == MODE_THREAD));

    // R12
    boot_lock_chk: assert property (@(posedge clk) disable iff (rst)
        !run |=> ($stable(mode_q) && $stable(ctrl_q)));

    // R6
    handler_priv_chk: assert property (@(posedge clk) disable iff (rst)
        mode_handler |-> (priv && !sel_psp));

endmodule

// File: rtl/mode_stack_ctrl.sv
module mode_stack_ctrl
    import mode_stack_pkg::*;
#(
    parameter int unsigned ADDR_W   = 32,
    parameter int unsigned DATA_W   = 32,
    parameter int unsigned EXC_W    = 8,
    parameter int unsigned SP_ALIGN = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              exc_enter,
    input  logic [EXC_W-1:0]  exc_num,
    input  logic              exc_return,
    input  logic              ctrl_wr,
    input  logic [1:0]        ctrl_wdata,
    input  logic              sp_wr,
    input  logic [DATA_W-1:0] sp_wdata,
    output logic              mem_req,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic              mem_valid,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              pc_load,
    output logic [DATA_W-1:0] pc_value,
    output logic              boot_done,
    output logic              mode_handler,
    output logic              priv,
    output logic              sp_sel_psp,
    output logic [DATA_W-1:0] msp,
    output logic [DATA_W-1:0] psp,
    output logic [EXC_W-1:0]  exc_field
);

    logic sp_boot_wr;

    boot_seq #(
        .ADDR_W(ADDR_W),
        .DATA_W(DATA_W)
    ) i_boot (
        .clk       (clk),
        .rst       (rst),
        .mem_valid (mem_valid),
        .mem_rdata (mem_rdata),
        .mem_req   (mem_req),
        .mem_addr  (mem_addr),
        .sp_boot_wr(sp_boot_wr),
        .pc_load   (pc_load),
        .pc_value  (pc_value),
        .boot_done (boot_done)
    );

    mode_tracker #(
        .EXC_W(EXC_W)
    ) i_mode (
        .clk         (clk),
        .rst         (rst),
        .run         (boot_done),
        .exc_enter   (exc_enter),
        .exc_num     (exc_num),
        .exc_return  (exc_return),
        .ctrl_wr     (ctrl_wr),
        .ctrl_wdata  (ctrl_wdata),
        .mode_handler(mode_handler),
        .priv        (priv),
        .sel_psp     (sp_sel_psp),
        .exc_field   (exc_field)
    );

    sp_bank #(
        .DATA_W  (DATA_W),
        .SP_ALIGN(SP_ALIGN)
    ) i_sp (
        .clk     (clk),
        .rst     (rst),
        .boot_wr (sp_boot_wr),
        .boot_val(mem_rdata),
        .sp_wr   (sp_wr && boot_done),
        .sel_psp (sp_sel_psp),
        .wdata   (sp_wdata),
        .msp     (msp),
        .psp     (psp)
    );

    // R12
    boot_sp_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (!boot_done && !mem_valid) |=> ($stable(msp) && $stable(psp)));

endmodule

// File: tb/test_mode_stack_ctrl.sv
module test_mode_stack_ctrl;

    localparam int unsigned ADDR_W = 32;
    localparam int unsigned DATA_W = 32;
    localparam int unsigned EXC_W  = 8;
    localparam logic [DATA_W-1:0] MASK = ~DATA_W'(3);

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              exc_enter = 1'b0;
    logic [EXC_W-1:0]  exc_num = '0;
    logic              exc_return = 1'b0;
    logic              ctrl_wr = 1'b0;
    logic [1:0]        ctrl_wdata = '0;
    logic              sp_wr = 1'b0;
    logic [DATA_W-1:0] sp_wdata = '0;
    logic              mem_req;
    logic [ADDR_W-1:0] mem_addr;
    logic              mem_valid = 1'b0;
    logic [DATA_W-1:0] mem_rdata = '0;
    logic              pc_load;
    logic [DATA_W-1:0] pc_value;
    logic              boot_done;
    logic              mode_handler;
    logic              priv;
    logic              sp_sel_psp;
    logic [DATA_W-1:0] msp;
    logic [DATA_W-1:0] psp;
    logic [EXC_W-1:0]  exc_field;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    // reference state
    logic             m_h, m_np, m_sp;
    logic [DATA_W-1:0] m_msp, m_psp;
    logic [EXC_W-1:0] m_exc;

    always #10 clk = ~clk;

    mode_stack_ctrl i_mode_stack_ctrl (
        .clk(clk), .rst(rst), .exc_enter(exc_enter), .exc_num(exc_num),
        .exc_return(exc_return), .ctrl_wr(ctrl_wr), .ctrl_wdata(ctrl_wdata),
        .sp_wr(sp_wr), .sp_wdata(sp_wdata), .mem_req(mem_req), .mem_addr(mem_addr),
        .mem_valid(mem_valid), .mem_rdata(mem_rdata), .pc_load(pc_load),
        .pc_value(pc_value), .boot_done(boot_done), .mode_handler(mode_handler),
        .priv(priv), .sp_sel_psp(sp_sel_psp), .msp(msp), .psp(psp), .exc_field(exc_field)
    );

    task automatic chk(input string req, input string what, input logic [DATA_W-1:0] act,
                       input logic [DATA_W-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    function automatic logic exp_priv();
        return m_h || !m_np;
    endfunction

    function automatic logic exp_sel();
        return !m_h && m_sp;
    endfunction

    task automatic cmp_all(input string req);
        chk(req, "mode_handler", DATA_W'(mode_handler), DATA_W'(m_h));
        chk(req, "priv", DATA_W'(priv), DATA_W'(exp_priv()));
        chk(req, "sp_sel_psp", DATA_W'(sp_sel_psp), DATA_W'(exp_sel()));
        chk(req, "exc_field", DATA_W'(exc_field), DATA_W'(m_exc));
        chk(req, "msp", msp, m_msp);
        chk(req, "psp", psp, m_psp);
        chk(req, "pc_load", DATA_W'(pc_load), '0);
    endtask

    // one cycle after boot: drive, predict, wait an edge, compare
    task automatic step(input string req, input logic en, input logic [EXC_W-1:0] num,
                        input logic ret, input logic cw, input logic [1:0] cd,
                        input logic sw, input logic [DATA_W-1:0] sd);
        logic sel;
        exc_enter = en; exc_num = num; exc_return = ret;
        ctrl_wr = cw; ctrl_wdata = cd; sp_wr = sw; sp_wdata = sd;
        sel = exp_sel();
        if (sw) begin
            if (sel) m_psp = sd & MASK;
            else     m_msp = sd & MASK;
        end
        if (cw && exp_priv()) begin
            m_np = cd[0];
            m_sp = cd[1];
        end
        if (en && num != '0) begin
            m_h = 1'b1; m_exc = num;
        end else if (ret && m_h) begin
            m_h = 1'b0; m_exc = '0;
        end
        @(negedge clk);
        cmp_all(req);
    endtask

    task automatic idle();
        exc_enter = 0; exc_return = 0; ctrl_wr = 0; sp_wr = 0;
    endtask

    task automatic do_boot(input int lat, input logic [DATA_W-1:0] spw,
                           input logic [DATA_W-1:0] pcw, input logic junk);
        rst = 1'b1; mem_valid = 1'b0;
        if (junk) begin
            exc_enter = 1; exc_num = 8'd9; exc_return = 1;
            ctrl_wr = 1; ctrl_wdata = 2'b11; sp_wr = 1; sp_wdata = 32'hdead_beef;
        end else idle();
        repeat (2) @(negedge clk);
        // R1 checked during reset
        chk("R1", "priv in reset", DATA_W'(priv), 1);
        chk("R1", "mode in reset", DATA_W'(mode_handler), 0);
        rst = 1'b0;
        @(negedge clk);
        chk("R1", "mode_handler", DATA_W'(mode_handler), 0);
        chk("R1", "priv", DATA_W'(priv), 1);
        chk("R1", "sp_sel_psp", DATA_W'(sp_sel_psp), 0);
        chk("R1", "psp", psp, 0);
        chk("R1", "exc_field", DATA_W'(exc_field), 0);
        chk("R1", "boot_done", DATA_W'(boot_done), 0);
        chk("R2", "mem_req first", DATA_W'(mem_req), 1);
        chk("R2", "mem_addr first", mem_addr, 0);
        repeat (lat) @(negedge clk);
        chk("R2", "addr held while waiting", mem_addr, 0);
        mem_valid = 1'b1; mem_rdata = spw;
        @(negedge clk);
        mem_valid = 1'b0;
        chk("R2", "msp from word 0", msp, spw & MASK);
        chk("R2", "mem_req second", DATA_W'(mem_req), 1);
        chk("R2", "mem_addr second", mem_addr, 4);
        repeat (lat) @(negedge clk);
        chk("R3", "no early load", DATA_W'(pc_load), 0);
        mem_valid = 1'b1; mem_rdata = pcw;
        @(negedge clk);
        mem_valid = 1'b0;
        chk("R3", "pc_load", DATA_W'(pc_load), 1);
        chk("R3", "pc_value", pc_value, pcw);
        chk("R3", "boot_done before run", DATA_W'(boot_done), 0);
        chk("R2", "msp kept", msp, spw & MASK);
        idle();
        @(negedge clk);
        chk("R3", "pc_load pulse ends", DATA_W'(pc_load), 0);
        chk("R3", "boot_done", DATA_W'(boot_done), 1);
        chk("R3", "mem_req idle", DATA_W'(mem_req), 0);
        m_h = 0; m_np = 0; m_sp = 0; m_exc = '0;
        m_msp = spw & MASK; m_psp = '0;
        // R12: junk strobes during boot left no trace
        cmp_all("R12");
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h1c0d_e5a7));
        do_boot(0, 32'h2000_1003, 32'h0000_0101, 1'b0);

        // R6: number 0 is ignored
        step("R6", 1, 8'd0, 0, 0, 2'b00, 0, '0);
        // R8: return in Thread ignored
        step("R8", 0, 8'd0, 1, 0, 2'b00, 0, '0);
        // R5 + R10: process stack selected from next edge
        step("R5", 0, 8'd0, 0, 1, 2'b10, 0, '0);
        chk("R10", "psp active after edge", DATA_W'(sp_sel_psp), 1);
        // R11: write goes to process stack only, aligned
        step("R11", 0, 8'd0, 0, 0, 2'b00, 1, 32'h1234_5677);
        // R6: Handler uses main stack, privileged
        step("R6", 1, 8'd255, 0, 0, 2'b00, 0, '0);
        // R11: in Handler the main stack takes the write
        step("R11", 0, 8'd0, 0, 0, 2'b00, 1, 32'h2000_0ffe);
        // R7: nested entry replaces number
        step("R7", 1, 8'd17, 0, 0, 2'b00, 0, '0);
        // R9: Handler write to user + process stack accepted
        step("R9", 0, 8'd0, 0, 1, 2'b11, 0, '0);
        // R8: entry beats return in same cycle
        step("R8", 1, 8'd3, 1, 0, 2'b00, 0, '0);
        // R8: return to Thread, now user level
        step("R8", 0, 8'd0, 1, 0, 2'b00, 0, '0);
        // R4: user Thread
        chk("R4", "user thread priv", DATA_W'(priv), 0);
        // R9: user write to regain privilege ignored
        step("R9", 0, 8'd0, 0, 1, 2'b00, 0, '0);
        chk("R9", "still user", DATA_W'(priv), 0);

        // R12: second boot with stall and junk strobes during boot
        do_boot(2, 32'h3fff_fffd, 32'h0800_0201, 1'b1);

        // R10: random mix checked every cycle
        for (int i = 0; i < 3000; i++) begin
            step("R10",
                 ($urandom % 8) == 0, EXC_W'($urandom),
                 ($urandom % 6) == 0,
                 ($urandom % 5) == 0, 2'($urandom),
                 ($urandom % 3) == 0, $urandom);
        end
        idle();
        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule